// File: doc/BRIEF.md
# Warp Launcher with Below-Half Compaction

This block keeps the warp slots of one SIMD processor busy. Ray work items arrive from the processor's own input queue. They are written into the lanes of a warp slot one at a time. When the slot is full, the warp is launched and becomes resident. Resident warps are offered for issue in round-robin order. Each issue carries the warp's lane-alive mask. The execution side reports finished lanes per warp. The block clears those lanes. When fewer than half of a warp's lanes are still alive, the warp is retired at once. Its surviving lanes stay where they are, and the slot is topped up with fresh queue items before it is relaunched. Retired slots are refilled before empty slots, so surviving rays run again ahead of work that has not started yet. A drain input lets a partly filled warp launch when the queue has run dry.

A three-state controller does the filling. Its states are S_IDLE, S_FILL and S_LAUNCH.
- From S_IDLE it moves to S_FILL as soon as any non-resident slot exists. It picks that slot on the same edge.
- In S_FILL it visits lanes from 0 upward, one lane per cycle. A lane that is already alive is skipped. A dead lane takes one queue item. If the queue is empty and drain is high, the dead lane is left empty. With no item and no drain, the controller waits on that lane.
- After the last lane it moves to S_LAUNCH. There the slot becomes resident if any lane is alive, and the controller then returns to S_IDLE.

Top module: `warp_launcher`

## Requirements
- R1: While reset is asserted, q_ready, wr_valid, lch_valid and iss_valid are all low.
- R2: Each accepted queue item (q_valid and q_ready high at an edge) is written to the lowest-numbered lane of the target slot that is not alive. In that same cycle, wr_valid is high and wr_warp, wr_lane and wr_ray name the slot, the lane and the item.
- R3: lch_valid pulses for one cycle per launch, with lch_warp naming the slot and lch_mask giving its alive lanes (bit i is lane i). A launch happens only when every lane is alive, or when drain was high while the queue was empty. Without drain, a partly filled slot never launches, however long the queue stays empty.
- R4: Every cycle in which any warp is resident, iss_valid is high. iss_warp is the next resident slot after the previously issued one, in ascending order with wrap-around. iss_mask is that slot's current alive mask.
- R5: A done report (done_valid high) for a resident warp clears the lanes set in done_mask from the next cycle. The warp stays resident when LANES/2 or more lanes remain. It stops being issued from the next cycle when fewer remain, so 16 of 32 stays and 15 of 32 retires.
- R6: A retired warp with no lanes left becomes an empty slot, and its next fill starts at lane 0. A retired warp with survivors keeps them in their lanes, and only its dead lanes are refilled.
- R7: When choosing the next slot to fill, a retired slot with survivors is preferred over an empty slot. Within each kind, the lowest slot index wins.
- R8: A done report naming a warp that is not resident has no effect on that warp's lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_valid | input | 1 | Input queue has an item |
| q_ray | input | RAY_W | Ray identifier at the queue head |
| q_ready | output | 1 | Launcher takes the queue head this cycle |
| drain | input | 1 | Allow partial launch when the queue is empty |
| wr_valid | output | 1 | A ray is written into a lane |
| wr_warp | output | WARP_W | Slot being written |
| wr_lane | output | LANE_W | Lane being written |
| wr_ray | output | RAY_W | Ray being written |
| lch_valid | output | 1 | A warp is launched this cycle |
| lch_warp | output | WARP_W | Launched slot |
| lch_mask | output | LANES | Alive lanes of the launched warp |
| iss_valid | output | 1 | A resident warp is issued |
| iss_warp | output | WARP_W | Issued slot |
| iss_mask | output | LANES | Alive lanes of the issued warp |
| done_valid | input | 1 | Lanes of a warp have finished |
| done_warp | input | WARP_W | Warp that the done report names |
| done_mask | input | LANES | Lanes that finished |

## Verification
The assertions take for granted that done_warp is below WARPS and that done reports arrive only for warps that have been issued. The bench keeps to this by naming only slots it has launched, plus one deliberate report for a slot that is being refilled. It also assumes q_ray is held steady while q_valid waits for q_ready. The bench changes queue inputs only just after an edge, and only after the previous item has been taken. Drain is raised only while the queue is empty, which is the case the launch rule assumes.

// File: rtl/wl_pkg.sv
package wl_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_FILL   = 2'd1,
        S_LAUNCH = 2'd2
    } wl_state_e;

endpackage

// File: rtl/wl_first_set.sv
module wl_first_set #(
    parameter int N  = 32,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/wl_rr_pick.sv
module wl_rr_pick #(
    parameter int N  = 32,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic          gnt_valid,
    output logic [IW-1:0] gnt_idx
);
    logic [IW-1:0] last_q;

    always_comb begin
        int j;
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int k = 1; k <= N; k++) begin
            j = int'(last_q) + k;
            if (j >= N) j = j - N;
            if (!gnt_valid && req[j]) begin
                gnt_valid = 1'b1;
                gnt_idx   = IW'(j);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         last_q <= IW'(N - 1);
        else if (gnt_valid) last_q <= gnt_idx;
    end

    // R4: a grant always names a requesting slot
    p_grant_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> req[gnt_idx]);
endmodule

// File: rtl/wl_lane_table.sv
module wl_lane_table #(
    parameter int WARPS = 32,
    parameter int LANES = 32,
    localparam int WARP_W = (WARPS > 1) ? $clog2(WARPS) : 1,
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int HALF   = LANES / 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           done_valid,
    input  logic [WARP_W-1:0]              done_warp,
    input  logic [LANES-1:0]               done_mask,
    input  logic                           set_valid,
    input  logic [WARP_W-1:0]              set_warp,
    input  logic [LANE_W-1:0]              set_lane,
    input  logic                           lch_valid,
    input  logic [WARP_W-1:0]              lch_warp,
    output logic [WARPS-1:0][LANES-1:0]    alive,
    output logic [WARPS-1:0]               resident,
    output logic [WARPS-1:0]               retiring
);
    logic [WARPS-1:0][LANES-1:0] alive_q;
    logic [WARPS-1:0]            res_q;
    logic [WARPS-1:0]            ret_q;
    logic [LANES-1:0]            nxt_mask;
    logic                        done_hit;

    assign done_hit = done_valid && res_q[done_warp];
    assign nxt_mask = alive_q[done_warp] & ~done_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alive_q <= '0;
            res_q   <= '0;
            ret_q   <= '0;
        end else begin
            if (done_hit) begin
                alive_q[done_warp] <= nxt_mask;
                if ($countones(nxt_mask) < HALF) begin
                    res_q[done_warp] <= 1'b0;
                    ret_q[done_warp] <= |nxt_mask;
                end
            end
            if (set_valid) alive_q[set_warp][set_lane] <= 1'b1;
            if (lch_valid) begin
                res_q[lch_warp] <= |alive_q[lch_warp];
                ret_q[lch_warp] <= 1'b0;
            end
        end
    end

    assign alive    = alive_q;
    assign resident = res_q;
    assign retiring = ret_q;

    // R2: a new ray never lands on a lane that is still alive
    p_set_dead_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |-> !alive_q[set_warp][set_lane]);

    // R5: below half alive retires the warp
    p_retire_below_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && res_q[done_warp]
         && ($countones(alive_q[done_warp] & ~done_mask) < HALF))
        |=> !res_q[$past(done_warp)]);

    // R5: half or more alive keeps the warp resident
    p_keep_at_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && res_q[done_warp]
         && ($countones(alive_q[done_warp] & ~done_mask) >= HALF))
        |=> res_q[$past(done_warp)]);

    // R8: done reports for non-resident warps leave the lanes alone
    p_ignore_idle_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !res_q[done_warp]
         && !(set_valid && set_warp == done_warp))
        |=> alive_q[$past(done_warp)] == $past(alive_q[done_warp]));
endmodule

// File: rtl/warp_launcher.sv
module warp_launcher #(
    parameter int WARPS = 32,
    parameter int LANES = 32,
    parameter int RAY_W = 16,
    localparam int WARP_W = (WARPS > 1) ? $clog2(WARPS) : 1,
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_valid,
    input  logic [RAY_W-1:0]  q_ray,
    output logic              q_ready,
    input  logic              drain,
    output logic              wr_valid,
    output logic [WARP_W-1:0] wr_warp,
    output logic [LANE_W-1:0] wr_lane,
    output logic [RAY_W-1:0]  wr_ray,
    output logic              lch_valid,
    output logic [WARP_W-1:0] lch_warp,
    output logic [LANES-1:0]  lch_mask,
    output logic              iss_valid,
    output logic [WARP_W-1:0] iss_warp,
    output logic [LANES-1:0]  iss_mask,
    input  logic              done_valid,
    input  logic [WARP_W-1:0] done_warp,
    input  logic [LANES-1:0]  done_mask
);
    import wl_pkg::*;

    wl_state_e                   state_q;
    logic [WARP_W-1:0]           tgt_q;
    logic [LANE_W-1:0]           lane_q;
    logic [WARPS-1:0][LANES-1:0] alive;
    logic [WARPS-1:0]            resident;
    logic [WARPS-1:0]            retiring;
    logic [WARPS-1:0]            empty_slots;
    logic                        ret_found, free_found;
    logic [WARP_W-1:0]           ret_idx, free_idx;
    logic                        cur_alive, advance, last_lane, lch_pulse;

    assign empty_slots = ~resident & ~retiring;

    wl_first_set #(.N(WARPS)) u_pick_ret (
        .req(retiring), .found(ret_found), .idx(ret_idx));
    wl_first_set #(.N(WARPS)) u_pick_free (
        .req(empty_slots), .found(free_found), .idx(free_idx));

    wl_rr_pick #(.N(WARPS)) u_rr (
        .clk(clk), .rst_n(rst_n), .req(resident),
        .gnt_valid(iss_valid), .gnt_idx(iss_warp));

    wl_lane_table #(.WARPS(WARPS), .LANES(LANES)) u_table (
        .clk(clk), .rst_n(rst_n),
        .done_valid(done_valid), .done_warp(done_warp), .done_mask(done_mask),
        .set_valid(wr_valid), .set_warp(tgt_q), .set_lane(lane_q),
        .lch_valid(lch_pulse), .lch_warp(tgt_q),
        .alive(alive), .resident(resident), .retiring(retiring));

    assign cur_alive = alive[tgt_q][lane_q];
    assign last_lane = (lane_q == LANE_W'(LANES - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            tgt_q   <= '0;
            lane_q  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (ret_found || free_found) begin
                        tgt_q   <= ret_found ? ret_idx : free_idx;
                        lane_q  <= '0;
                        state_q <= S_FILL;
                    end
                end
                S_FILL: begin
                    if (advance) begin
                        if (last_lane) state_q <= S_LAUNCH;
                        else           lane_q  <= lane_q + 1'b1;
                    end
                end
                S_LAUNCH: state_q <= S_IDLE;
                default:  state_q <= S_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        q_ready   = 1'b0;
        advance   = 1'b0;
        lch_pulse = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_FILL: begin
                q_ready = !cur_alive;
                advance = cur_alive || q_valid || drain;
            end
            S_LAUNCH: lch_pulse = 1'b1;
            default: ;
        endcase
    end

    assign wr_valid  = q_ready && q_valid;
    assign wr_warp   = tgt_q;
    assign wr_lane   = lane_q;
    assign wr_ray    = q_ray;
    assign lch_valid = lch_pulse && (|alive[tgt_q]);
    assign lch_warp  = tgt_q;
    assign lch_mask  = alive[tgt_q];
    assign iss_mask  = alive[iss_warp];

    // R3: a launch is full unless drain allowed a partial one
    p_launch_full_or_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lch_valid |-> ((&lch_mask) || $past(drain)));

    // R3: a launch pulse lasts one cycle
    p_launch_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lch_valid |=> !lch_valid);

    // R4: an issued warp always has live lanes
    p_issue_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (|iss_mask));
endmodule

// File: tb/warp_launcher_tb.sv
module warp_launcher_tb;
    localparam int WARPS  = 4;
    localparam int LANES  = 32;
    localparam int RAY_W  = 16;
    localparam int WARP_W = 2;
    localparam int LANE_W = 5;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              q_valid, drain;
    logic [RAY_W-1:0]  q_ray;
    logic              q_ready;
    logic              wr_valid;
    logic [WARP_W-1:0] wr_warp;
    logic [LANE_W-1:0] wr_lane;
    logic [RAY_W-1:0]  wr_ray;
    logic              lch_valid;
    logic [WARP_W-1:0] lch_warp;
    logic [LANES-1:0]  lch_mask;
    logic              iss_valid;
    logic [WARP_W-1:0] iss_warp;
    logic [LANES-1:0]  iss_mask;
    logic              done_valid;
    logic [WARP_W-1:0] done_warp;
    logic [LANES-1:0]  done_mask;

    int checks = 0;
    int fails  = 0;
    logic [LANES-1:0] m_alive [WARPS];
    bit               m_res   [WARPS];

    always #2 clk = ~clk;

    warp_launcher #(.WARPS(WARPS), .LANES(LANES), .RAY_W(RAY_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .q_valid(q_valid), .q_ray(q_ray), .q_ready(q_ready), .drain(drain),
        .wr_valid(wr_valid), .wr_warp(wr_warp), .wr_lane(wr_lane), .wr_ray(wr_ray),
        .lch_valid(lch_valid), .lch_warp(lch_warp), .lch_mask(lch_mask),
        .iss_valid(iss_valid), .iss_warp(iss_warp), .iss_mask(iss_mask),
        .done_valid(done_valid), .done_warp(done_warp), .done_mask(done_mask));

    task automatic chk(input string req, input bit ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int first_dead(input logic [LANES-1:0] m);
        for (int i = 0; i < LANES; i++) if (!m[i]) return i;
        return -1;
    endfunction

    // feed n items into slot w; after they are taken, wait hold cycles, then raise drain if asked
    task automatic run_fill(input int w, input int n, input int base, input int hold,
                            input bit use_drain, input string req);
        int  k = 0;
        int  hold_left = hold;
        bit  seen = 0;
        q_valid = (n > 0);
        q_ray   = RAY_W'(base);
        drain   = 1'b0;
        for (int c = 0; c < 400 && !seen; c++) begin
            @(negedge clk);
            if (wr_valid) begin
                int el;
                el = first_dead(m_alive[w]);
                chk({req, " write slot"}, wr_warp == WARP_W'(w), wr_warp, w);
                chk({req, " write lane"}, int'(wr_lane) == el, wr_lane, el);
                chk({req, " write ray"}, wr_ray == RAY_W'(base + k), wr_ray, base + k);
                if (el >= 0) m_alive[w][el] = 1'b1;
                k++;
            end
            if (lch_valid) begin
                chk({req, " R3 launch only if full or drained"},
                    (&m_alive[w]) || drain, lch_mask, m_alive[w]);
                chk({req, " R3 launch slot"}, lch_warp == WARP_W'(w), lch_warp, w);
                chk({req, " R3 launch mask"}, lch_mask == m_alive[w], lch_mask, m_alive[w]);
                m_res[w] = (m_alive[w] != '0);
                seen = 1;
            end
            @(posedge clk); #1;
            q_ray = RAY_W'(base + k);
            if (k >= n) begin
                q_valid = 1'b0;
                if (hold_left > 0) hold_left--;
                else drain = use_drain;
            end
        end
        if (!seen) chk({req, " launch timeout"}, 1'b0, 0, 1);
        drain = 1'b0;
    endtask

    task automatic do_done(input int w, input logic [LANES-1:0] m);
        @(negedge clk);
        done_valid = 1'b1;
        done_warp  = WARP_W'(w);
        done_mask  = m;
        if (m_res[w]) begin
            m_alive[w] = m_alive[w] & ~m;
            if ($countones(m_alive[w]) < LANES / 2) m_res[w] = 0;
        end
        @(posedge clk); #1;
        done_valid = 1'b0;
        done_mask  = '0;
    endtask

    task automatic check_rr(input string req);
        int prev = -1;
        bit any;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            any = 0;
            for (int i = 0; i < WARPS; i++) any |= m_res[i];
            chk({req, " R4 issue valid"}, iss_valid == any, iss_valid, any);
            if (iss_valid) begin
                chk({req, " R4 issued slot resident"}, m_res[iss_warp], iss_warp, 1);
                chk({req, " R4 issue mask"}, iss_mask == m_alive[iss_warp], iss_mask, m_alive[iss_warp]);
                if (prev >= 0) begin
                    int nx = prev;
                    for (int k = 1; k <= WARPS; k++) begin
                        if (m_res[(prev + k) % WARPS]) begin nx = (prev + k) % WARPS; break; end
                    end
                    chk({req, " R4 round robin"}, int'(iss_warp) == nx, iss_warp, nx);
                end
                prev = int'(iss_warp);
            end
            @(posedge clk); #1;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; q_valid = 1'b0; q_ray = '0; drain = 1'b0;
        done_valid = 1'b0; done_warp = '0; done_mask = '0;
        for (int i = 0; i < WARPS; i++) begin m_alive[i] = '0; m_res[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 q_ready", q_ready == 1'b0, q_ready, 0);
        chk("R1 wr_valid", wr_valid == 1'b0, wr_valid, 0);
        chk("R1 lch_valid", lch_valid == 1'b0, lch_valid, 0);
        chk("R1 iss_valid", iss_valid == 1'b0, iss_valid, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic t_fill_all();
        for (int w = 0; w < WARPS; w++) run_fill(w, LANES, 256 * (w + 1), 0, 0, "R2 full fill");
    endtask

    task automatic t_threshold();
        do_done(1, 32'h0000_FFFF);      // 16 remain: stays (R5)
        check_rr("R5 sixteen stay");
        do_done(1, 32'h0001_0000);      // 15 remain: retires (R5)
        check_rr("R5 fifteen retire");
    endtask

    task automatic t_ignore_and_priority();
        do_done(1, 32'h0010_0000);      // R8: slot 1 is being refilled, not resident
        do_done(0, 32'hFFFF_FFFF);      // R6: no survivors, slot becomes empty
        do_done(2, 32'h000F_FFFF);      // 12 remain: retires with survivors
        run_fill(1, 17, 16'h500, 0, 0, "R8 R6 survivors kept");
        run_fill(2, 20, 16'h600, 0, 0, "R7 retired before empty");
    endtask

    task automatic t_drain();
        run_fill(0, 5, 16'h700, 40, 1, "R3 R6 drain partial");
        check_rr("R4 with partial warp");
    endtask

    initial begin
        t_reset();
        t_fill_all();
        check_rr("R4 four resident");
        t_threshold();
        t_ignore_and_priority();
        t_drain();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule